// File: doc/BRIEF.md
# DRAM Controller with Selectable Refresh Scheduling

This block connects a simple CPU request port to a dynamic RAM whose address pins are shared between row and column. A CPU access is accepted as one word. The upper address bits go onto the shared bus first, with the row strobe. The lower bits follow with the column strobe. Read data is captured from the memory, or write data is driven onto it. After each access both strobes return high for a precharge time.

The stored charge decays, so the controller refreshes rows on its own, using RAS-only cycles taken from an internal row counter. A mode input selects how refresh is scheduled. In distributed mode, one row is refreshed each refresh interval, between CPU accesses. In burst mode, all rows are refreshed consecutively once every full refresh period, and CPU access waits until the burst is over. A pending refresh wins over a new CPU request, but it never cuts into an access that has already started.

Top module: `dram_ctrl`

## Requirements
- R1: After reset, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high and `cpu_ack` is low. The first refresh after reset uses row 0.
- R2: An access drives row bits `cpu_addr[7:4]` on `dram_addr` and pulls `dram_ras_n` low. Exactly T_RCD (2) cycles later it drives column bits `cpu_addr[3:0]` and pulls `dram_cas_n` low. After T_CAS (2) cycles both strobes rise together. The CAS strobe is only ever low while RAS is low.
- R3: A write (`cpu_wr`=1) holds `dram_we_n` low, and `dram_dq_oe` high with the write data, for the whole CAS phase. `dram_we_n` is never low outside CAS.
- R4: A read returns on `cpu_rdata` the word most recently written to the same address.
- R5: Once RAS rises, it stays high for at least T_RP (2) cycles before it falls again.
- R6: A refresh holds RAS low for T_RAS (3) cycles while CAS stays high. Its row is the refresh counter, which advances by one after each refresh and wraps from 15 to 0.
- R7: With `refresh_burst`=0, one row is refreshed every REF_INTERVAL (64) cycles.
- R8: With `refresh_burst`=1, no refresh happens between bursts. Every 16 intervals, all 16 rows are refreshed with RAS falls spaced T_RAS+T_RP cycles apart. A CPU request raised during a burst is served only after the 16th refresh.
- R9: A pending refresh is started before a waiting CPU request, so refresh still happens while the CPU requests continuously. An access in progress always completes its full sequence.
- R10: `cpu_ack` is a single-cycle pulse. It comes in the first cycle after the CAS phase, with both strobes high, and for a read `cpu_rdata` is valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_burst | input | 1 | 1 selects burst refresh, 0 selects distributed refresh |
| cpu_req | input | 1 | CPU access request, held until acknowledged |
| cpu_wr | input | 1 | 1 for write, 0 for read |
| cpu_addr | input | 8 | Word address: row in the upper half, column in the lower half |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid with the acknowledge |
| cpu_ack | output | 1 | One-cycle completion pulse |
| dram_addr | output | 4 | Shared row/column address bus |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_dq_out | output | 8 | Data driven to the memory |
| dram_dq_oe | output | 1 | Drive enable for `dram_dq_out` |
| dram_dq_in | input | 8 | Data returned by the memory |

## Verification
Several rules are checked on every cycle:
- CAS is only ever low while RAS is low.
- Write enable is only ever low while CAS is low.
- The address stays stable while RAS alone is low.
- RAS always gets a precharge gap after it rises.
- The acknowledge is a single pulse that comes with both strobes idle.

Other behaviours only the bench's scenarios can show: the row and column values sent for each CPU address, data integrity through the memory model, and the refresh row sequence with its wrap. They also cover how many refreshes each mode yields over time, the 16-row burst holding off a CPU request, and refresh priority under continuous CPU traffic.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ACT  = 3'd1,
        ST_CAS  = 3'd2,
        ST_PRE  = 3'd3,
        ST_REF  = 3'd4,
        ST_REFP = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_ROW = 2'd0,
        SEL_COL = 2'd1,
        SEL_REF = 2'd2
    } addr_sel_e;

endpackage

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W = 4,
    parameter int COL_W = 4,
    parameter int BUS_W = 4
) (
    input  logic [ROW_W+COL_W-1:0] word_addr,
    input  logic [ROW_W-1:0]       ref_row,
    input  addr_sel_e              sel,
    output logic [BUS_W-1:0]       bus
);
    localparam int ADDR_W = ROW_W + COL_W;

    always_comb begin
        case (sel)
            SEL_ROW: bus = BUS_W'(word_addr[ADDR_W-1:COL_W]);
            SEL_COL: bus = BUS_W'(word_addr[COL_W-1:0]);
            SEL_REF: bus = BUS_W'(ref_row);
            default: bus = '0;
        endcase
    end
endmodule

// File: rtl/dram_ref_timer.sv
module dram_ref_timer #(
    parameter int INTERVAL = 64,
    parameter int ROWS     = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic burst_mode,
    input  logic grant,
    output logic pending,
    output logic burst
);
    localparam int CNT_W  = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int TICK_W = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam logic [CNT_W-1:0]  CNT_LAST  = CNT_W'(INTERVAL - 1);
    localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(ROWS - 1);

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [TICK_W-1:0] ticks;
        logic              pend;
        logic              burst;
    } tmr_t;

    tmr_t q, d;

    always_comb begin
        d = q;
        if (grant) d.pend = 1'b0;
        if (q.cnt == CNT_LAST) begin
            d.cnt = '0;
            if (burst_mode) begin
                if (q.ticks == TICK_LAST) begin
                    d.ticks = '0;
                    d.pend  = 1'b1;
                    d.burst = 1'b1;
                end else begin
                    d.ticks = q.ticks + 1'b1;
                end
            end else begin
                d.ticks = '0;
                d.pend  = 1'b1;
                d.burst = 1'b0;
            end
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign pending = q.pend;
    assign burst   = q.burst;
endmodule

// File: rtl/dram_ctrl.sv
module dram_ctrl
    import dram_ctrl_pkg::*;
#(
    parameter int ROW_W        = 4,
    parameter int COL_W        = 4,
    parameter int DATA_W       = 8,
    parameter int T_RCD        = 2,
    parameter int T_CAS        = 2,
    parameter int T_RP         = 2,
    parameter int T_RAS        = 3,
    parameter int REF_INTERVAL = 64
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  refresh_burst,
    input  logic                                  cpu_req,
    input  logic                                  cpu_wr,
    input  logic [ROW_W+COL_W-1:0]                cpu_addr,
    input  logic [DATA_W-1:0]                     cpu_wdata,
    output logic [DATA_W-1:0]                     cpu_rdata,
    output logic                                  cpu_ack,
    output logic [((ROW_W>COL_W)?ROW_W:COL_W)-1:0] dram_addr,
    output logic                                  dram_ras_n,
    output logic                                  dram_cas_n,
    output logic                                  dram_we_n,
    output logic [DATA_W-1:0]                     dram_dq_out,
    output logic                                  dram_dq_oe,
    input  logic [DATA_W-1:0]                     dram_dq_in
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int TM1    = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int TM2    = (T_RP > T_RAS) ? T_RP : T_RAS;
    localparam int TMAX   = (TM1 > TM2) ? TM1 : TM2;
    localparam int TW     = $clog2(TMAX + 1);
    localparam logic [TW-1:0]    RCD_LAST = TW'(T_RCD - 1);
    localparam logic [TW-1:0]    CAS_LAST = TW'(T_CAS - 1);
    localparam logic [TW-1:0]    RP_LAST  = TW'(T_RP - 1);
    localparam logic [TW-1:0]    RAS_LAST = TW'(T_RAS - 1);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

    typedef struct packed {
        seq_state_e        state;
        logic [TW-1:0]     cnt;
        logic [ROW_W-1:0]  ref_row;
        logic [ROW_W-1:0]  ref_left;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              ack;
    } seq_t;

    seq_t      q, d;
    logic      ref_pend, ref_burst, ref_grant;
    addr_sel_e sel;

    dram_ref_timer #(
        .INTERVAL (REF_INTERVAL),
        .ROWS     (ROWS)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .burst_mode (refresh_burst),
        .grant      (ref_grant),
        .pending    (ref_pend),
        .burst      (ref_burst)
    );

    always_comb begin
        d         = q;
        d.ack     = 1'b0;
        ref_grant = 1'b0;
        case (q.state)
            ST_IDLE: begin
                if (ref_pend) begin
                    ref_grant  = 1'b1;
                    d.state    = ST_REF;
                    d.cnt      = '0;
                    d.ref_left = ref_burst ? ROW_LAST : '0;
                end else if (cpu_req) begin
                    d.state = ST_ACT;
                    d.cnt   = '0;
                    d.wr    = cpu_wr;
                    d.addr  = cpu_addr;
                    d.wdata = cpu_wdata;
                end
            end
            ST_ACT: begin
                if (q.cnt == RCD_LAST) begin
                    d.state = ST_CAS;
                    d.cnt   = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_CAS: begin
                if (q.cnt == CAS_LAST) begin
                    if (!q.wr) d.rdata = dram_dq_in;
                    d.ack   = 1'b1;
                    d.state = ST_PRE;
                    d.cnt   = '0;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_PRE: begin
                if (q.cnt == RP_LAST) d.state = ST_IDLE;
                else                  d.cnt   = q.cnt + 1'b1;
            end
            ST_REF: begin
                if (q.cnt == RAS_LAST) begin
                    d.state   = ST_REFP;
                    d.cnt     = '0;
                    d.ref_row = (q.ref_row == ROW_LAST) ? '0 : q.ref_row + 1'b1;
                end else d.cnt = q.cnt + 1'b1;
            end
            ST_REFP: begin
                if (q.cnt == RP_LAST) begin
                    d.cnt = '0;
                    if (q.ref_left != '0) begin
                        d.ref_left = q.ref_left - 1'b1;
                        d.state    = ST_REF;
                    end else d.state = ST_IDLE;
                end else d.cnt = q.cnt + 1'b1;
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        case (q.state)
            ST_CAS:           sel = SEL_COL;
            ST_REF, ST_REFP:  sel = SEL_REF;
            default:          sel = SEL_ROW;
        endcase
    end

    dram_addr_mux #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .BUS_W (BUS_W)
    ) u_mux (
        .word_addr (q.addr),
        .ref_row   (q.ref_row),
        .sel       (sel),
        .bus       (dram_addr)
    );

    assign dram_ras_n  = !(q.state == ST_ACT || q.state == ST_CAS || q.state == ST_REF);
    assign dram_cas_n  = !(q.state == ST_CAS);
    assign dram_dq_oe  = (q.state == ST_CAS) && q.wr;
    assign dram_we_n   = !dram_dq_oe;
    assign dram_dq_out = q.wdata;
    assign cpu_ack     = q.ack;
    assign cpu_rdata   = q.rdata;
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
    parameter int BUS_W = 4,
    parameter int T_RP  = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] dram_addr,
    input logic             dram_ras_n,
    input logic             dram_cas_n,
    input logic             dram_we_n,
    input logic             cpu_ack
);
    // R2
    cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_cas_n |-> !dram_ras_n);

    // R2
    row_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && dram_cas_n && !$past(dram_ras_n) && $past(dram_cas_n))
        |-> $stable(dram_addr));

    // R3
    we_in_cas_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> !dram_cas_n);

    // R10
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R10
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |-> (dram_ras_n && dram_cas_n));

    generate
        if (T_RP > 1) begin : g_pre
            // R5
            precharge_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(dram_ras_n) |=> dram_ras_n);
        end
    endgenerate
endmodule

bind dram_ctrl dram_ctrl_chk #(
    .BUS_W (BUS_W),
    .T_RP  (T_RP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dram_addr  (dram_addr),
    .dram_ras_n (dram_ras_n),
    .dram_cas_n (dram_cas_n),
    .dram_we_n  (dram_we_n),
    .cpu_ack    (cpu_ack)
);

// File: tb/dram_ctrl_tb.sv
`timescale 1ns/1ps
module dram_ctrl_tb;
    localparam int T_RCD = 2, T_CAS = 2, T_RP = 2, T_RAS = 3, INTV = 64, ROWS = 16;

    logic       clk = 1'b0, rst_n = 1'b0, refresh_burst = 1'b0;
    logic       cpu_req = 1'b0, cpu_wr = 1'b0, cpu_ack;
    logic [7:0] cpu_addr = '0, cpu_wdata = '0, cpu_rdata;
    logic [3:0] dram_addr;
    logic       dram_ras_n, dram_cas_n, dram_we_n, dram_dq_oe;
    logic [7:0] dram_dq_out, dram_dq_in;

    always #4 clk = ~clk;

    dram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .refresh_burst(refresh_burst),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ack(cpu_ack),
        .dram_addr(dram_addr), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out), .dram_dq_oe(dram_dq_oe),
        .dram_dq_in(dram_dq_in)
    );

    int errors = 0, checks = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // memory stub and bus monitor, on the falling edge
    logic [7:0] mem [256];
    logic [3:0] st_row = '0, st_col = '0;
    assign dram_dq_in = mem[{st_row, st_col}];

    int  cyc = 0, ras_fall = 0, cas_fall = 0, ras_rise = -100;
    int  ref_cnt = 0, exp_ref = 0, run = 0, last_ref_fall = -100;
    bit  had_cas = 1'b0, p_ras = 1'b1, p_cas = 1'b1, p_ack = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (!dram_ras_n && p_ras) begin
                st_row   = dram_addr;
                ras_fall = cyc;
                had_cas  = 1'b0;
                chk(cyc - ras_rise >= T_RP, "R5", "precharge cycles", cyc - ras_rise, T_RP);
            end
            if (!dram_cas_n && p_cas) begin
                st_col   = dram_addr;
                cas_fall = cyc;
                had_cas  = 1'b1;
                chk(cyc - ras_fall == T_RCD, "R2", "RAS to CAS cycles", cyc - ras_fall, T_RCD);
            end
            if (!dram_cas_n && !dram_we_n && dram_dq_oe) mem[{st_row, st_col}] = dram_dq_out;
            if (dram_ras_n && !p_ras) begin
                ras_rise = cyc;
                if (!had_cas) begin
                    chk(st_row == 4'(exp_ref), "R6", "refresh row", st_row, exp_ref);
                    chk(cyc - ras_fall == T_RAS, "R6", "refresh RAS width", cyc - ras_fall, T_RAS);
                    run = (ras_fall - last_ref_fall == T_RAS + T_RP) ? run + 1 : 1;
                    last_ref_fall = ras_fall;
                    exp_ref = (exp_ref + 1) % ROWS;
                    ref_cnt++;
                end else begin
                    chk(dram_cas_n && !p_cas, "R2", "strobes rise together", int'(dram_cas_n), 1);
                    chk(cyc - cas_fall == T_CAS, "R2", "CAS cycles", cyc - cas_fall, T_CAS);
                end
            end
            if (cpu_ack)
                chk(!p_ack && dram_ras_n && dram_cas_n, "R10", "ack single pulse while idle",
                    int'(p_ack), 0);
        end
        p_ras = dram_ras_n;
        p_cas = dram_cas_n;
        p_ack = cpu_ack;
    end

    task automatic do_access(input bit wr, input logic [7:0] a, input logic [7:0] wd,
                             output logic [7:0] rd);
        cpu_req   = 1'b1;
        cpu_wr    = wr;
        cpu_addr  = a;
        cpu_wdata = wd;
        do @(negedge clk); while (!cpu_ack);
        rd      = cpu_rdata;
        cpu_req = 1'b0;
        chk({st_row, st_col} == a, "R2", "row/column sent", {st_row, st_col}, a);
    endtask

    // {write, address, write data, expected read data}
    localparam logic [24:0] VEC [8] = '{
        {1'b1, 8'h00, 8'h5A, 8'h00},
        {1'b1, 8'hFF, 8'hA5, 8'h00},
        {1'b1, 8'h3C, 8'h11, 8'h00},
        {1'b1, 8'hC3, 8'hEE, 8'h00},
        {1'b0, 8'hC3, 8'h00, 8'hEE},
        {1'b0, 8'h00, 8'h00, 8'h5A},
        {1'b0, 8'h3C, 8'h00, 8'h11},
        {1'b0, 8'hFF, 8'h00, 8'hA5}
    };

    initial begin
        logic [7:0] rd;
        int r0, waited;
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes idle in reset",
            int'({dram_ras_n, dram_cas_n, dram_we_n}), 7);
        chk(!cpu_ack, "R1", "ack low in reset", int'(cpu_ack), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(dram_ras_n && dram_cas_n && !cpu_ack, "R1", "idle after reset",
            int'({dram_ras_n, dram_cas_n, cpu_ack}), 6);

        // R3/R4: vector table, distributed refresh running underneath
        for (int i = 0; i < 8; i++) begin
            do_access(VEC[i][24], VEC[i][23:16], VEC[i][15:8], rd);
            if (!VEC[i][24]) chk(rd == VEC[i][7:0], "R4", "read data", rd, VEC[i][7:0]);
            else chk(mem[VEC[i][23:16]] == VEC[i][15:8], "R3", "word stored by write",
                     mem[VEC[i][23:16]], VEC[i][15:8]);
        end

        // R7: one refresh per interval when idle
        r0 = ref_cnt;
        repeat (10 * INTV) @(negedge clk);
        chk(ref_cnt - r0 >= 9 && ref_cnt - r0 <= 11, "R7", "refreshes in 10 intervals",
            ref_cnt - r0, 10);

        // R8: burst of all rows, CPU held off
        refresh_burst = 1'b1;
        r0 = ref_cnt;
        waited = 0;
        while (ref_cnt == r0 && waited < 3000) begin @(negedge clk); waited++; end
        chk(ref_cnt != r0, "R8", "burst started", ref_cnt - r0, 1);
        do_access(1'b0, 8'h00, 8'h00, rd);
        chk(run == ROWS, "R8", "consecutive refreshes before access served", run, ROWS);
        chk(rd == 8'h5A, "R4", "read after burst", rd, 8'h5A);
        r0 = ref_cnt;
        repeat (3 * INTV) @(negedge clk);
        chk(ref_cnt == r0, "R8", "no single refresh between bursts", ref_cnt - r0, 0);

        // R9: refresh wins over continuous CPU traffic
        refresh_burst = 1'b0;
        r0 = ref_cnt;
        for (int i = 0; i < 40; i++) do_access(1'b1, 8'(i * 7), 8'(i + 1), rd);
        chk(ref_cnt - r0 >= 3, "R9", "refreshes during continuous requests", ref_cnt - r0, 4);
        do_access(1'b0, 8'(39 * 7), 8'h00, rd);
        chk(rd == 8'd40, "R9", "data intact after mixed traffic", rd, 40);

        // R6: counter wraps after the burst and distributed refreshes
        chk(exp_ref == ref_cnt % ROWS, "R6", "refresh counter wrap tracking", exp_ref, ref_cnt % ROWS);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule